// File: doc/BRIEF.md
# Oldest-First Issue Queue

This block holds renamed instructions until they can run, then hands exactly one of them per cycle to register read and execution. Each queued entry keeps the instruction tag, two physical source register indices with a busy flag each, and the functional-unit class it needs. The execute stage reports, per class, whether a unit can accept an instruction this cycle. A completion broadcast names the physical register just written and clears every busy flag in the queue that refers to it.

Selection is by age among eligible entries. An entry is eligible when both sources are free and a unit of its class is available. The oldest eligible entry wins, so a younger ready instruction overtakes an older one that is still waiting. Relative age is held in an age matrix that is updated on every insertion, so ordering stays correct however entries leave. A flush empties the queue in one cycle, and the enqueue port applies back-pressure when every slot is occupied.

Top module: `oldest_first_iq`

## Requirements
- R1: After reset the queue is empty: `disp_valid` is 0 and `enq_ready` is 1.
- R2: An entry whose source 0 or source 1 is still busy is never dispatched.
- R3: Class codes are ALU=0, MEM=1, CSR=2, and `unit_free[c]` reports class c. An entry is dispatched only in a cycle where the bit for its class is 1.
- R4: Among eligible entries, the one enqueued earliest is dispatched first.
- R5: A younger eligible entry is dispatched ahead of an older entry that is not eligible.
- R6: A completion with `wake_valid` clears the busy flag of every queued source equal to `wake_preg`, in any number of entries and in both source positions. The affected entries become eligible in the next cycle.
- R7: When an enqueue and a completion for the same register happen in one cycle, the new entry is stored with that source already free. It can dispatch in the following cycle.
- R8: At most one entry is dispatched per cycle. `disp_tag`, `disp_src0`, `disp_src1` and `disp_cls` carry the selected entry's fields. A dispatched entry leaves the queue and is not dispatched again.
- R9: When all DEPTH slots are occupied, `enq_ready` is 0, and an enqueue offered in that state is dropped.
- R10: `flush` invalidates all entries at the next edge. In the flush cycle, `disp_valid` is 0 and any enqueue offered is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New instruction offered |
| enq_ready | output | 1 | Queue has a free slot |
| enq_tag | input | TAG_W | Instruction tag |
| enq_src0 | input | PREG_W | Physical source 0 |
| enq_src0_busy | input | 1 | Source 0 not yet produced |
| enq_src1 | input | PREG_W | Physical source 1 |
| enq_src1_busy | input | 1 | Source 1 not yet produced |
| enq_cls | input | CLS_W | Unit class (0 ALU, 1 MEM, 2 CSR) |
| wake_valid | input | 1 | Completion broadcast valid |
| wake_preg | input | PREG_W | Completed physical register |
| unit_free | input | NCLS | Per-class unit availability |
| flush | input | 1 | Discard all entries |
| disp_valid | output | 1 | An entry is dispatched this cycle |
| disp_tag | output | TAG_W | Tag of dispatched entry |
| disp_src0 | output | PREG_W | Source 0 of dispatched entry |
| disp_src1 | output | PREG_W | Source 1 of dispatched entry |
| disp_cls | output | CLS_W | Class of dispatched entry |

## Verification
The bench targets these cases:
- A stalled old entry behind ready young ones. A pure FIFO pick would then hang or issue out of turn.
- A completion that matches two entries and both source positions at once. A design with a single-match wakeup would leave one entry stuck.
- An enqueue that lands in the same cycle as the completion it depends on. A design that misses this would strand the entry with a stale busy flag.
- Offering a ninth entry to a full queue, and flushing while an enqueue and a free unit are both present. A wrong design would then overwrite a slot, dispatch into the flush, or resurrect the dropped instruction, which shows up as an unexpected tag at the dispatch port.

// File: rtl/oldest_first_iq.sv
module oldest_first_iq #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 6,
  parameter int PREG_W = 7,
  parameter int NCLS   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enq_valid,
  output logic                        enq_ready,
  input  logic [TAG_W-1:0]            enq_tag,
  input  logic [PREG_W-1:0]           enq_src0,
  input  logic                        enq_src0_busy,
  input  logic [PREG_W-1:0]           enq_src1,
  input  logic                        enq_src1_busy,
  input  logic [$clog2(NCLS)-1:0]     enq_cls,
  input  logic                        wake_valid,
  input  logic [PREG_W-1:0]           wake_preg,
  input  logic [NCLS-1:0]             unit_free,
  input  logic                        flush,
  output logic                        disp_valid,
  output logic [TAG_W-1:0]            disp_tag,
  output logic [PREG_W-1:0]           disp_src0,
  output logic [PREG_W-1:0]           disp_src1,
  output logic [$clog2(NCLS)-1:0]     disp_cls
);
  localparam int CLS_W = $clog2(NCLS);
  localparam int CLS_N = 1 << CLS_W;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]             valid_q, b0_q, b1_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0][PREG_W-1:0] s0_q, s1_q;
  logic [DEPTH-1:0][CLS_W-1:0]  cls_q;
  // older_q[j][i] set: entry j was enqueued before entry i
  logic [DEPTH-1:0][DEPTH-1:0]  older_q;

  logic [CLS_N-1:0] free_pad;
  logic [DEPTH-1:0] elig, blocked, sel;
  logic [IDX_W-1:0] free_idx;
  logic             enq_fire, sel_busy;

  always_comb begin
    free_pad = '0;
    free_pad[NCLS-1:0] = unit_free;
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDX_W'(i);
  end

  assign enq_ready = ~&valid_q;
  assign enq_fire  = enq_valid & enq_ready & ~flush;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      elig[i] = valid_q[i] & ~b0_q[i] & ~b1_q[i] & free_pad[cls_q[i]];
    for (int i = 0; i < DEPTH; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (elig[j] && older_q[j][i]) blocked[i] = 1'b1;
      sel[i] = elig[i] & ~blocked[i];
    end
  end

  always_comb begin
    disp_tag  = '0;
    disp_src0 = '0;
    disp_src1 = '0;
    disp_cls  = '0;
    sel_busy  = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (sel[i]) begin
        disp_tag  = disp_tag  | tag_q[i];
        disp_src0 = disp_src0 | s0_q[i];
        disp_src1 = disp_src1 | s1_q[i];
        disp_cls  = disp_cls  | cls_q[i];
        sel_busy  = sel_busy  | b0_q[i] | b1_q[i];
      end
  end

  assign disp_valid = (|sel) & ~flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wake_valid && valid_q[i] && s0_q[i] == wake_preg) b0_q[i] <= 1'b0;
        if (wake_valid && valid_q[i] && s1_q[i] == wake_preg) b1_q[i] <= 1'b0;
        if (sel[i]) valid_q[i] <= 1'b0;
      end
      if (enq_fire) begin
        valid_q[free_idx] <= 1'b1;
        tag_q[free_idx]   <= enq_tag;
        s0_q[free_idx]    <= enq_src0;
        s1_q[free_idx]    <= enq_src1;
        cls_q[free_idx]   <= enq_cls;
        b0_q[free_idx]    <= enq_src0_busy & ~(wake_valid && enq_src0 == wake_preg);
        b1_q[free_idx]    <= enq_src1_busy & ~(wake_valid && enq_src1 == wake_preg);
        older_q[free_idx] <= '0;
        for (int j = 0; j < DEPTH; j++)
          if (IDX_W'(j) != free_idx) older_q[j][free_idx] <= valid_q[j];
      end
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel)); // R8
  AST_OPERANDS_FREE: assert property (@(posedge clk) disable iff (!rst_n) disp_valid |-> !sel_busy); // R2
  AST_UNIT_AVAILABLE: assert property (@(posedge clk) disable iff (!rst_n) disp_valid |-> free_pad[disp_cls]); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n) (&valid_q) |-> !enq_ready); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !disp_valid); // R10
endmodule

// File: tb/oldest_first_iq_bench.sv
`timescale 1ns/1ps
module oldest_first_iq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_ready;
  logic [5:0] enq_tag = '0;
  logic [6:0] enq_src0 = '0, enq_src1 = '0;
  logic enq_src0_busy = 1'b0, enq_src1_busy = 1'b0;
  logic [1:0] enq_cls = '0;
  logic wake_valid = 1'b0;
  logic [6:0] wake_preg = '0;
  logic [2:0] unit_free = '0;
  logic flush = 1'b0;
  logic disp_valid;
  logic [5:0] disp_tag;
  logic [6:0] disp_src0, disp_src1;
  logic [1:0] disp_cls;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [5:0] exp_tag[$];
  logic [1:0] exp_cls[$];
  logic [6:0] exp_s0[$];
  string      exp_req[$];

  always #2 clk = ~clk;

  oldest_first_iq u_oldest_first_iq (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_tag(enq_tag), .enq_src0(enq_src0), .enq_src0_busy(enq_src0_busy),
    .enq_src1(enq_src1), .enq_src1_busy(enq_src1_busy), .enq_cls(enq_cls),
    .wake_valid(wake_valid), .wake_preg(wake_preg), .unit_free(unit_free),
    .flush(flush), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_src0(disp_src0), .disp_src1(disp_src1), .disp_cls(disp_cls));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_disp(input logic [5:0] t, input logic [1:0] c, input logic [6:0] s0, input string req);
    exp_tag.push_back(t); exp_cls.push_back(c); exp_s0.push_back(s0); exp_req.push_back(req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enq(input logic [5:0] t, input logic [6:0] s0, input logic b0,
                     input logic [6:0] s1, input logic b1, input logic [1:0] c);
    enq_valid = 1'b1; enq_tag = t; enq_src0 = s0; enq_src0_busy = b0;
    enq_src1 = s1; enq_src1_busy = b1; enq_cls = c;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic chk_drained(input string req);
    check(exp_tag.size() == 0, req, exp_tag.size(), 0);
    exp_tag.delete(); exp_cls.delete(); exp_s0.delete(); exp_req.delete();
  endtask

  // monitor: compare each dispatch against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && disp_valid) begin
      if (exp_tag.size() == 0) begin
        check(1'b0, "R8 unexpected dispatch", disp_tag, -1);
      end else begin
        automatic logic [5:0] t = exp_tag.pop_front();
        automatic logic [1:0] c = exp_cls.pop_front();
        automatic logic [6:0] s = exp_s0.pop_front();
        automatic string r = exp_req.pop_front();
        check(disp_tag == t, r, disp_tag, t);
        check(disp_cls == c && disp_src0 == s, {r, " R8 fields"}, {disp_cls, disp_src0}, {c, s});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    #1;
    check(disp_valid == 1'b0, "R1 disp_valid", disp_valid, 0);
    check(enq_ready == 1'b1, "R1 enq_ready", enq_ready, 1);
    idle(1);

    // R2/R4/R6: two ready ALU ops then one waiting on preg 5
    enq(6'd1, 7'd1, 0, 7'd2, 0, 2'd0);
    enq(6'd2, 7'd3, 0, 7'd4, 0, 2'd0);
    enq(6'd3, 7'd5, 1, 7'd6, 0, 2'd0);
    expect_disp(6'd1, 2'd0, 7'd1, "R4 order");
    expect_disp(6'd2, 2'd0, 7'd3, "R4 order");
    unit_free = 3'b001;
    idle(3);
    check(disp_valid == 1'b0, "R2 busy held", disp_valid, 0);
    expect_disp(6'd3, 2'd0, 7'd5, "R6 wake");
    wake_valid = 1'b1; wake_preg = 7'd5;
    idle(1);
    wake_valid = 1'b0;
    idle(2);
    chk_drained("R6 drained");

    // R3/R5: MEM older, ALU younger; only CSR free first
    unit_free = 3'b000;
    enq(6'd4, 7'd8, 0, 7'd9, 0, 2'd1);
    enq(6'd5, 7'd10, 0, 7'd11, 0, 2'd0);
    unit_free = 3'b100;
    #1;
    check(disp_valid == 1'b0, "R3 no unit", disp_valid, 0);
    idle(1);
    expect_disp(6'd5, 2'd0, 7'd10, "R3 ALU only");
    unit_free = 3'b001;
    idle(1);
    expect_disp(6'd4, 2'd1, 7'd8, "R3 MEM free");
    unit_free = 3'b010;
    idle(2);
    chk_drained("R3 drained");

    // R5: older stalled on preg 7, younger ready
    unit_free = 3'b000;
    enq(6'd6, 7'd7, 1, 7'd12, 0, 2'd0);
    enq(6'd7, 7'd13, 0, 7'd14, 0, 2'd0);
    expect_disp(6'd7, 2'd0, 7'd13, "R5 bypass");
    unit_free = 3'b001;
    idle(2);
    expect_disp(6'd6, 2'd0, 7'd7, "R5 older after wake");
    wake_valid = 1'b1; wake_preg = 7'd7;
    idle(1);
    wake_valid = 1'b0;
    idle(2);
    chk_drained("R5 drained");

    // R6: one broadcast frees both sources and two entries
    unit_free = 3'b000;
    enq(6'd8, 7'd9, 1, 7'd9, 1, 2'd0);
    enq(6'd9, 7'd3, 0, 7'd9, 1, 2'd0);
    wake_valid = 1'b1; wake_preg = 7'd9;
    idle(1);
    wake_valid = 1'b0;
    expect_disp(6'd8, 2'd0, 7'd9, "R6 multi match");
    expect_disp(6'd9, 2'd0, 7'd3, "R6 multi match");
    unit_free = 3'b001;
    idle(3);
    chk_drained("R6 multi drained");

    // R7: enqueue and completion of same register together
    expect_disp(6'd10, 2'd0, 7'd12, "R7 same cycle wake");
    wake_valid = 1'b1; wake_preg = 7'd12;
    enq(6'd10, 7'd12, 1, 7'd13, 0, 2'd0);
    wake_valid = 1'b0;
    idle(2);
    chk_drained("R7 drained");

    // R9: fill, offer one more, then drain in order
    unit_free = 3'b000;
    for (int k = 0; k < 8; k++) enq(6'(11 + k), 7'(20 + k), 0, 7'd0, 0, 2'd2);
    #1;
    check(enq_ready == 1'b0, "R9 full", enq_ready, 0);
    enq(6'd40, 7'd40, 0, 7'd0, 0, 2'd2);
    enq(6'd40, 7'd40, 0, 7'd0, 0, 2'd2);
    for (int k = 0; k < 8; k++) expect_disp(6'(11 + k), 2'd2, 7'(20 + k), "R9 order");
    unit_free = 3'b100;
    idle(10);
    chk_drained("R9 drained");
    #1;
    check(enq_ready == 1'b1, "R9 ready again", enq_ready, 1);

    // R10: flush with competing enqueue and free unit
    unit_free = 3'b000;
    idle(1);
    enq(6'd30, 7'd1, 0, 7'd2, 0, 2'd0);
    enq(6'd31, 7'd1, 0, 7'd2, 0, 2'd0);
    enq(6'd32, 7'd1, 0, 7'd2, 0, 2'd0);
    flush = 1'b1; unit_free = 3'b001;
    enq_valid = 1'b1; enq_tag = 6'd33; enq_src0_busy = 1'b0; enq_src1_busy = 1'b0; enq_cls = 2'd0;
    #1;
    check(disp_valid == 1'b0, "R10 flush cycle", disp_valid, 0);
    idle(1);
    flush = 1'b0; enq_valid = 1'b0;
    #1;
    check(disp_valid == 1'b0, "R10 emptied", disp_valid, 0);
    check(enq_ready == 1'b1, "R10 ready", enq_ready, 1);
    idle(3);
    chk_drained("R10 drained");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule